// File: doc/BRIEF.md
# Serial Bus Hold Gate

This block sits between the serial pins of a memory device and its serial command engine and implements the active-low pause input. While a pause is in force, the block withholds the serial clock edges from the engine and turns off the data output driver. Chip select stays low throughout. The engine's own state, and any array operation it has already started, is not touched. The engine therefore resumes at exactly the bit where it stopped.

The block runs on a fast system clock. It synchronises the serial clock, chip select and pause pins, and turns serial clock transitions into single-cycle rise and fall enables for the engine. Entry into and exit from the pause follow the serial clock level. When the pause pin changes while the serial clock is low, the change takes effect at once. When the serial clock is high, the change waits for the next falling serial clock edge. When the engine reports a four-bit-wide transfer, the pause pin carries data, and the pause function is bypassed.

Top module: `spi_hold_gate`

## Requirements
- R1: During and right after reset, hold_active_o, sck_rise_en_o, sck_fall_en_o and pad_oe_o are all 0.
- R2: When the pause pin is low, chip select is low and the synchronised serial clock is low, the block is paused (hold_active_o = 1) one clock after the synchronised pause level is seen.
- R3: When the pause pin falls while the serial clock is high, the block is not yet paused. The next falling serial clock edge is still passed as sck_fall_en_o, and the pause starts after it. If the pause pin returns high before that edge, no pause occurs.
- R4: When the pause pin rises while the serial clock is low, the pause ends one clock after the synchronised level is seen.
- R5: When the pause pin rises while the serial clock is high, the pause continues. The next falling serial clock edge is withheld from the engine, and the pause ends after it.
- R6: While paused, sck_rise_en_o and sck_fall_en_o stay 0 and pad_oe_o is 0.
- R7: When not paused and chip select is low, pad_oe_o follows eng_oe_i in the same cycle. pad_do_o always equals eng_do_i.
- R8: While chip select is high, no serial clock enables are produced, pad_oe_o is 0 and any pause is cleared. If the pause pin is still low when chip select returns low, the pause applies again.
- R9: While eng_quad_i is 1, the pause pin is ignored: serial clock enables pass, pad_oe_o follows eng_oe_i and hold_active_o is 0.
- R10: Each serial clock edge seen outside a pause yields exactly one enable pulse. No edge is repeated, so a transfer resumes at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low chip select pin |
| hold_n_i | input | 1 | Active-low pause pin |
| eng_do_i | input | DATA_W | Output data from the command engine |
| eng_oe_i | input | 1 | Output enable request from the command engine |
| eng_quad_i | input | 1 | Engine reports a four-bit-wide transfer (pause bypass) |
| sck_rise_en_o | output | 1 | One-cycle enable for a rising serial clock edge |
| sck_fall_en_o | output | 1 | One-cycle enable for a falling serial clock edge |
| pad_do_o | output | DATA_W | Data towards the output pad |
| pad_oe_o | output | 1 | Output pad driver enable |
| hold_active_o | output | 1 | Pause currently in force |

## Verification
A pin change made between clock edges reaches the edge enables after SYNC_STAGES rising clock edges. It reaches hold_active_o one edge later, because the pause state is registered behind the synchroniser. pad_oe_o answers eng_oe_i and eng_quad_i within the same cycle. The bench drives every input at the falling clock edge. It advances a behavioural model, with its own delay line and a two-rule pause formula, at each rising edge, and compares all outputs 1 ns later. Every output is therefore checked in the exact cycle it is due. Rise enables from the design and from the model are also totalled over the whole run and compared.

// File: rtl/shg_pkg.sv
package shg_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_HELD  = 2'd2,
    ST_EXIT  = 2'd3
  } hold_st_e;

  function automatic logic st_is_held(hold_st_e s);
    return (s == ST_HELD) || (s == ST_EXIT);
  endfunction

  // Next pause state; sck_lvl is the synchronised serial clock level.
  function automatic hold_st_e st_next(hold_st_e cur, logic sel, logic bypass,
                                       logic hold_req, logic sck_lvl, logic sck_fall);
    hold_st_e n;
    n = cur;
    if (!sel || bypass) begin
      n = ST_RUN;
    end else begin
      case (cur)
        ST_RUN:   if (hold_req) n = sck_lvl ? ST_ENTER : ST_HELD;
        ST_ENTER: if (!hold_req) n = ST_RUN;
                  else if (sck_fall || !sck_lvl) n = ST_HELD;
        ST_HELD:  if (!hold_req) n = sck_lvl ? ST_EXIT : ST_RUN;
        ST_EXIT:  if (hold_req) n = ST_HELD;
                  else if (sck_fall || !sck_lvl) n = ST_RUN;
        default:  n = ST_RUN;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/shg_sync.sv
module shg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q_o = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/shg_edge.sv
module shg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl_i;
  end
  assign rise_o = lvl_i & ~lvl_d;
  assign fall_o = ~lvl_i & lvl_d;
endmodule

// File: rtl/shg_hold_fsm.sv
module shg_hold_fsm
  import shg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic bypass_i,
  input  logic hold_req_i,
  input  logic sck_lvl_i,
  input  logic sck_fall_i,
  output logic held_o,
  output logic enter_pend_o,
  output logic exit_pend_o
);
  hold_st_e st_q, st_d;

  assign st_d = st_next(st_q, sel_i, bypass_i, hold_req_i, sck_lvl_i, sck_fall_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign held_o       = st_is_held(st_q);
  assign enter_pend_o = (st_q == ST_ENTER);
  assign exit_pend_o  = (st_q == ST_EXIT);

  // R2 / R3: a pause only starts while the serial clock is low
  a_r2_enter_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> !$past(sck_lvl_i));

  // R4 / R5: a pause ends on a low serial clock unless deselected or bypassed
  a_r5_exit_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held_o) && $past(sel_i) && !$past(bypass_i)) |-> !$past(sck_lvl_i));

  // R8: deselection clears the pause
  a_r8_desel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !held_o);

  // R9: bypass clears the pause
  a_r9_bypass_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> !held_o);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic [DATA_W-1:0] eng_do_i,
  input  logic              eng_oe_i,
  input  logic              eng_quad_i,
  output logic              sck_rise_en_o,
  output logic              sck_fall_en_o,
  output logic [DATA_W-1:0] pad_do_o,
  output logic              pad_oe_o,
  output logic              hold_active_o
);
  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b011; // {sck, cs_n, hold_n}

  logic [PIN_W-1:0] pins_s;
  logic s_sck, s_cs_n, s_hold_n;
  logic sck_rise, sck_fall;
  logic sel, held, enter_pend, exit_pend, held_eff;

  shg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sck_i, cs_n_i, hold_n_i}),
    .q_o(pins_s)
  );
  assign {s_sck, s_cs_n, s_hold_n} = pins_s;
  assign sel = ~s_cs_n;

  shg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(s_sck),
    .rise_o(sck_rise), .fall_o(sck_fall)
  );

  shg_hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sel_i(sel), .bypass_i(eng_quad_i), .hold_req_i(~s_hold_n),
    .sck_lvl_i(s_sck), .sck_fall_i(sck_fall),
    .held_o(held), .enter_pend_o(enter_pend), .exit_pend_o(exit_pend)
  );

  assign held_eff      = held & ~eng_quad_i;
  assign sck_rise_en_o = sck_rise & sel & ~held_eff;
  assign sck_fall_en_o = sck_fall & sel & ~held_eff;
  assign pad_oe_o      = eng_oe_i & sel & ~held_eff;
  assign pad_do_o      = eng_do_i;
  assign hold_active_o = held_eff;

  // R6: nothing reaches the engine or the pad while paused
  a_r6_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active_o |-> !(sck_rise_en_o || sck_fall_en_o || pad_oe_o));

  // R3: the falling edge that starts a pending pause still reaches the engine
  a_r3_pend_fall_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_pend && sck_fall && sel && !eng_quad_i) |-> sck_fall_en_o);

  // R5: the falling edge that ends a pending exit is withheld
  a_r5_exit_fall_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pend && !eng_quad_i) |-> !sck_fall_en_o);

  // R8: no enables while deselected
  a_r8_no_edge_desel: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs_n |-> !(sck_rise_en_o || sck_fall_en_o || pad_oe_o));
endmodule

// File: tb/sim_spi_hold_gate.sv
module sim_spi_hold_gate;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic [0:0] eng_do = 1'b0;
  logic eng_oe = 1'b1, eng_quad = 1'b0;
  logic rise_en, fall_en, pad_oe, hold_act;
  logic [0:0] pad_do;

  int n_run = 0, n_fail = 0;
  int dut_rises = 0, mdl_rises = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  spi_hold_gate #(.SYNC_STAGES(NS), .DATA_W(1)) u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .eng_do_i(eng_do), .eng_oe_i(eng_oe), .eng_quad_i(eng_quad),
    .sck_rise_en_o(rise_en), .sck_fall_en_o(fall_en),
    .pad_do_o(pad_do), .pad_oe_o(pad_oe), .hold_active_o(hold_act)
  );

  task automatic chk(string t, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  // behavioural reference: delay line plus a two-rule pause formula
  bit q_sck[NS], q_cs[NS], q_hold[NS];
  bit m_prev, m_held;

  always @(posedge clk) begin
    bit s, sl, hl, eh;
    if (!rst_n) begin
      foreach (q_sck[i]) begin q_sck[i] = 0; q_cs[i] = 1; q_hold[i] = 1; end
      m_prev = 0; m_held = 0;
    end else begin
      s = q_sck[NS-1]; sl = !q_cs[NS-1]; hl = !q_hold[NS-1];
      if (!sl || eng_quad) m_held = 0;
      else if (!s)         m_held = hl;
      m_prev = s;
      for (int i = NS-1; i > 0; i--) begin
        q_sck[i] = q_sck[i-1]; q_cs[i] = q_cs[i-1]; q_hold[i] = q_hold[i-1];
      end
      q_sck[0] = sck; q_cs[0] = cs_n; q_hold[0] = hold_n;
    end
    #1;
    if (rst_n) begin
      s = q_sck[NS-1]; sl = !q_cs[NS-1];
      eh = m_held && !eng_quad;
      chk(tag, "rise_en", rise_en, s && !m_prev && sl && !eh);
      chk(tag, "fall_en", fall_en, !s && m_prev && sl && !eh);
      chk(tag, "pad_oe", pad_oe, eng_oe && sl && !eh);
      chk(tag, "hold_active", hold_act, eh);
      chk("R7", "pad_do", pad_do[0], eng_do[0]);
      if (rise_en) dut_rises++;          // R10 tally
      if (s && !m_prev && sl && !eh) mdl_rises++;
    end
  end

  always @(negedge clk) if (rst_n) eng_do <= ~eng_do;

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sck = 1'b1; wait_cyc(3);
      @(negedge clk) sck = 1'b0; wait_cyc(3);
    end
  endtask

  task automatic probe(string t, logic exp_hold);
    @(posedge clk); #1;
    chk(t, "probe hold_active", hold_act, exp_hold);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    wait_cyc(3);
    #1;
    chk("R1", "rst rise_en", rise_en, 1'b0);
    chk("R1", "rst pad_oe", pad_oe, 1'b0);
    chk("R1", "rst hold", hold_act, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    probe("R1", 1'b0);

    // R7: plain traffic, output enable follows the engine
    tag = "R7";
    @(negedge clk) cs_n = 1'b0;
    pulse(3);
    @(negedge clk) eng_oe = 1'b0; wait_cyc(2);
    @(negedge clk) eng_oe = 1'b1;
    pulse(1);

    // R2 / R4: pause and release with the serial clock low
    tag = "R2";
    @(negedge clk) hold_n = 1'b0; wait_cyc(5);
    probe("R2", 1'b1);
    tag = "R6";
    pulse(2);
    tag = "R4";
    @(negedge clk) hold_n = 1'b1; wait_cyc(5);
    probe("R4", 1'b0);
    pulse(2);

    // R3 / R5: pause and release with the serial clock high
    tag = "R3";
    @(negedge clk) sck = 1'b1; wait_cyc(5);
    @(negedge clk) hold_n = 1'b0; wait_cyc(5);
    probe("R3", 1'b0);
    @(negedge clk) sck = 1'b0; wait_cyc(5);
    probe("R3", 1'b1);
    tag = "R6";
    @(negedge clk) sck = 1'b1; wait_cyc(5);
    tag = "R5";
    @(negedge clk) hold_n = 1'b1; wait_cyc(5);
    probe("R5", 1'b1);
    @(negedge clk) sck = 1'b0; wait_cyc(5);
    probe("R5", 1'b0);
    pulse(2);

    // R3: pause request withdrawn before the falling edge
    tag = "R3";
    @(negedge clk) sck = 1'b1; wait_cyc(3);
    @(negedge clk) hold_n = 1'b0; wait_cyc(3);
    @(negedge clk) hold_n = 1'b1; wait_cyc(5);
    @(negedge clk) sck = 1'b0; wait_cyc(5);
    probe("R3", 1'b0);

    // R8: deselect during a pause
    tag = "R8";
    @(negedge clk) hold_n = 1'b0; wait_cyc(5);
    @(negedge clk) cs_n = 1'b1; wait_cyc(5);
    probe("R8", 1'b0);
    pulse(2);
    @(negedge clk) cs_n = 1'b0; wait_cyc(5);
    probe("R8", 1'b1);
    @(negedge clk) hold_n = 1'b1; wait_cyc(5);

    // R9: four-bit-wide transfer bypasses the pause pin
    tag = "R9";
    @(negedge clk) eng_quad = 1'b1; hold_n = 1'b0; wait_cyc(5);
    probe("R9", 1'b0);
    pulse(2);
    @(negedge clk) eng_quad = 1'b0; wait_cyc(3);
    probe("R9", 1'b1);
    @(negedge clk) hold_n = 1'b1; wait_cyc(5);
    pulse(2);

    // R10: every visible edge delivered once
    wait_cyc(4);
    chk("R10", "rise total match", dut_rises == mdl_rises, 1'b1);
    chk("R10", "rise total nonzero", dut_rises > 10, 1'b1);
    summary();
  end
endmodule